// File: doc/BRIEF.md
# Stream Multiply-Accumulate Cell

A single cell of an output-stationary systolic grid. Operands arrive on two valid/ready streams, one from the west and one from the north. Each stream message is an operand plus a mode flag. The cell queues each stream separately. It multiplies every matched west/north pair and adds the product into a private accumulator. It forwards the west operand eastward and the north operand southward, so that neighbouring cells see the same data one hop later.

A pair whose two flags are both set tells the cell to hand over its result. The accumulator value then leaves through the south port, the east port carries a zero operand, and the accumulator restarts from zero for the next matrix. A pair whose flags disagree is a protocol violation. It is consumed, produces no output and raises a one-cycle error pulse. Both output ports are registered. A pair is taken only when both output registers can accept new data, so the two operand flows always stay aligned.

Top module: `systolic_mac_cell`

## Requirements
- R1: Every message is OP_W+1 bits: bit OP_W (bit 32 by default) is the mode flag and bits OP_W-1..0 hold a two's-complement operand.
- R2: Each input owns a queue of Q_DEPTH (default 2) entries; its ready is high exactly while that queue holds fewer than Q_DEPTH entries, whatever the output ports are doing.
- R3: A pair with both flags 0 sends the west message unchanged east and the north message unchanged south, and adds west*north (modulo 2^OP_W) to the accumulator.
- R4: A pair with both flags 1 sends {1, accumulator} south and {1, zero} east, then clears the accumulator to zero.
- R5: A pair is consumed only when both queues are non-empty and both output registers are free (empty, or being taken in that cycle); a stall on either output therefore stalls both input flows.
- R6: A pair whose flags differ is consumed with no output and no accumulator change, and proto_err is high for exactly the one cycle after that consumption.
- R7: With no stalls, a pair accepted at clock edge k appears on the east and south outputs right after edge k+1.
- R8: A valid output that is not taken keeps its valid and data unchanged, and the output sequences do not depend on source or sink stall patterns.
- R9: Synchronous active-high reset empties the queues and output registers, clears proto_err and zeroes the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| west_vld | input | 1 | West message valid |
| west_rdy | output | 1 | West queue can accept |
| west_msg | input | OP_W+1 | West flag and operand |
| north_vld | input | 1 | North message valid |
| north_rdy | output | 1 | North queue can accept |
| north_msg | input | OP_W+1 | North flag and operand |
| east_vld | output | 1 | East message valid |
| east_rdy | input | 1 | East consumer ready |
| east_msg | output | OP_W+1 | Forwarded west operand, or zero in result mode |
| south_vld | output | 1 | South message valid |
| south_rdy | input | 1 | South consumer ready |
| south_msg | output | OP_W+1 | Forwarded north operand, or the accumulator in result mode |
| proto_err | output | 1 | One-cycle pulse for a pair with mismatched flags |

## Verification
A pair accepted at one edge is popped at the next edge, so the outputs are valid after two edges. The error pulse appears in the same cycle as those outputs would, and input ready reflects queue occupancy one edge after a transfer. The bench drives its inputs on the falling edge and samples every handshake and the error pulse a moment later, before the next rising edge. Each value it reads is therefore the one settled by the preceding rising edge. The latency test checks the empty cycle and then the valid cycle at those exact points. The stream sweeps compare whole ordered sequences, so they do not depend on when each output arrives.

// File: rtl/mac_cell_pkg.sv
package mac_cell_pkg;

  typedef enum logic [1:0] {
    PAIR_MAC    = 2'd0,
    PAIR_RESULT = 2'd1,
    PAIR_BAD    = 2'd2
  } pair_kind_e;

endpackage

// File: rtl/mac_cell_fifo.sv
module mac_cell_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  output logic         in_rdy,
  input  logic [W-1:0] in_data,
  output logic         out_ne,
  output logic [W-1:0] out_data,
  input  logic         pop
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push;

  assign in_rdy   = (count != FULL);
  assign push     = in_vld && in_rdy;
  assign out_ne   = (count != '0);
  assign out_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2: the consumer never pops an empty queue
  a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));

endmodule

// File: rtl/mac_cell_core.sv
module mac_cell_core
  import mac_cell_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          w_ne,
  input  logic          n_ne,
  input  logic [OP_W:0] w_msg,
  input  logic [OP_W:0] n_msg,
  input  logic          e_free,
  input  logic          s_free,
  output logic          pop,
  output logic          load,
  output logic [OP_W:0] e_nxt,
  output logic [OP_W:0] s_nxt,
  output logic          proto_err
);

  pair_kind_e      kind;
  logic [OP_W-1:0] acc_q;
  logic [OP_W-1:0] prod;
  logic            fire;

  always_comb begin
    case ({w_msg[OP_W], n_msg[OP_W]})
      2'b00:   kind = PAIR_MAC;
      2'b11:   kind = PAIR_RESULT;
      default: kind = PAIR_BAD;
    endcase
  end

  assign fire = w_ne && n_ne && e_free && s_free;
  assign pop  = fire;
  assign load = fire && (kind != PAIR_BAD);
  assign prod = w_msg[OP_W-1:0] * n_msg[OP_W-1:0];

  always_comb begin
    if (kind == PAIR_RESULT) begin
      e_nxt = {1'b1, {OP_W{1'b0}}};
      s_nxt = {1'b1, acc_q};
    end else begin
      e_nxt = w_msg;
      s_nxt = n_msg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= fire && (kind == PAIR_BAD);
      if (fire && kind == PAIR_MAC)    acc_q <= acc_q + prod;
      if (fire && kind == PAIR_RESULT) acc_q <= '0;
    end
  end

  // R4: a handed-over result leaves a zero accumulator behind
  a_r4_acc_clear: assert property (@(posedge clk) disable iff (rst)
    (fire && kind == PAIR_RESULT) |=> (acc_q == '0));

endmodule

// File: rtl/mac_cell_slot.sv
module mac_cell_slot #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic         free,
  output logic         o_vld,
  input  logic         o_rdy,
  output logic [W-1:0] o_data
);

  assign free = !o_vld || o_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
    end else if (ld) begin
      o_vld <= 1'b1;
    end else if (o_rdy) begin
      o_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ld) o_data <= d;
  end

  // R8: an output that is not taken stays put
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (o_vld && !o_rdy) |=> (o_vld && $stable(o_data)));

endmodule

// File: rtl/systolic_mac_cell.sv
module systolic_mac_cell #(
  parameter int OP_W    = 32,
  parameter int Q_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          west_vld,
  output logic          west_rdy,
  input  logic [OP_W:0] west_msg,
  input  logic          north_vld,
  output logic          north_rdy,
  input  logic [OP_W:0] north_msg,
  output logic          east_vld,
  input  logic          east_rdy,
  output logic [OP_W:0] east_msg,
  output logic          south_vld,
  input  logic          south_rdy,
  output logic [OP_W:0] south_msg,
  output logic          proto_err
);

  localparam int MSG_W = OP_W + 1;

  // index 0: west input / east output, index 1: north input / south output
  logic [1:0]       q_vld, q_rdy, q_ne;
  logic [MSG_W-1:0] q_in  [2];
  logic [MSG_W-1:0] q_out [2];
  logic [1:0]       sl_free, sl_vld, sl_rdy;
  logic [MSG_W-1:0] sl_d    [2];
  logic [MSG_W-1:0] sl_data [2];
  logic             pop, load;

  assign q_vld    = {north_vld, west_vld};
  assign q_in[0]  = west_msg;
  assign q_in[1]  = north_msg;
  assign west_rdy  = q_rdy[0];
  assign north_rdy = q_rdy[1];

  for (genvar i = 0; i < 2; i++) begin : g_in
    mac_cell_fifo #(.W(MSG_W), .DEPTH(Q_DEPTH)) u_q (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (q_vld[i]),
      .in_rdy   (q_rdy[i]),
      .in_data  (q_in[i]),
      .out_ne   (q_ne[i]),
      .out_data (q_out[i]),
      .pop      (pop)
    );
  end

  mac_cell_core #(.OP_W(OP_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .w_ne      (q_ne[0]),
    .n_ne      (q_ne[1]),
    .w_msg     (q_out[0]),
    .n_msg     (q_out[1]),
    .e_free    (sl_free[0]),
    .s_free    (sl_free[1]),
    .pop       (pop),
    .load      (load),
    .e_nxt     (sl_d[0]),
    .s_nxt     (sl_d[1]),
    .proto_err (proto_err)
  );

  assign sl_rdy = {south_rdy, east_rdy};

  for (genvar i = 0; i < 2; i++) begin : g_out
    mac_cell_slot #(.W(MSG_W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .ld     (load),
      .d      (sl_d[i]),
      .free   (sl_free[i]),
      .o_vld  (sl_vld[i]),
      .o_rdy  (sl_rdy[i]),
      .o_data (sl_data[i])
    );
  end

  assign east_vld  = sl_vld[0];
  assign east_msg  = sl_data[0];
  assign south_vld = sl_vld[1];
  assign south_msg = sl_data[1];

  // R4: a flagged east message always carries a zero operand
  a_r4_east_zero: assert property (@(posedge clk) disable iff (rst)
    (east_vld && east_msg[OP_W]) |-> (east_msg[OP_W-1:0] == '0));

endmodule

// File: tb/systolic_mac_cell_tb.sv
module systolic_mac_cell_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        w_vld = 1'b0, n_vld = 1'b0, e_rdy = 1'b0, s_rdy = 1'b0;
  logic        w_rdy, n_rdy, e_vld, s_vld, perr;
  logic [32:0] w_data = '0, n_data = '0;
  logic [32:0] e_data, s_data;

  always #2.5 clk = ~clk;

  systolic_mac_cell u_dut (
    .clk(clk), .rst(rst),
    .west_vld(w_vld), .west_rdy(w_rdy), .west_msg(w_data),
    .north_vld(n_vld), .north_rdy(n_rdy), .north_msg(n_data),
    .east_vld(e_vld), .east_rdy(e_rdy), .east_msg(e_data),
    .south_vld(s_vld), .south_rdy(s_rdy), .south_msg(s_data),
    .proto_err(perr)
  );

  int checks = 0, fails = 0;
  logic [31:0] rs = 32'h1234_5678;

  logic [32:0] w_src [64];
  logic [32:0] n_src [64];
  logic [32:0] exp_e [64];
  logic [32:0] exp_s [64];
  int n_pairs, n_exp, n_err_exp;
  int wi, ni, ei, si, errs;

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit coin(input int pct);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return (rs % 100) < pct;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; w_vld = 0; n_vld = 0; e_rdy = 0; s_rdy = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // scenario construction with arithmetic expected values (R1, R3, R4, R6)
  task automatic build(input int s);
    logic [31:0] acc, x, wv, nv;
    acc = 0; n_pairs = 0; n_exp = 0; n_err_exp = 0;
    for (int job = 0; job < 4; job++) begin
      for (int p = 0; p < (s + job * 3) % 5 + (s == 5 ? 3 : 0); p++) begin
        x = 32'(s * 977 + n_pairs * 131 + 7);
        if (s == 0) begin
          wv = (x % 11) - 5;
          nv = ((x >> 3) % 9) - 4;
        end else begin
          wv = x * 32'h9E37_79B1;
          nv = (x ^ 32'h55) * 32'h85EB_CA6B;
        end
        if (s >= 3 && (n_pairs % 4) == 2) begin
          w_src[n_pairs] = {n_pairs[0], wv};
          n_src[n_pairs] = {~n_pairs[0], nv};
          n_err_exp++;
        end else begin
          w_src[n_pairs] = {1'b0, wv};
          n_src[n_pairs] = {1'b0, nv};
          exp_e[n_exp] = {1'b0, wv};
          exp_s[n_exp] = {1'b0, nv};
          acc = acc + wv * nv;
          n_exp++;
        end
        n_pairs++;
      end
      w_src[n_pairs] = {1'b1, 32'hDEAD_0000 + 32'(job)};
      n_src[n_pairs] = {1'b1, 32'h0000_BEEF};
      exp_e[n_exp] = {1'b1, 32'h0};
      exp_s[n_exp] = {1'b1, acc};
      acc = 0;
      n_pairs++;
      n_exp++;
    end
  endtask

  task automatic step(input bit src_on, input int mode);
    @(negedge clk);
    w_vld = src_on && wi < n_pairs && (mode == 0 || mode == 2 || coin(55));
    n_vld = src_on && ni < n_pairs && (mode == 0 || mode == 2 || coin(45));
    w_data = (wi < n_pairs) ? w_src[wi] : '0;
    n_data = (ni < n_pairs) ? n_src[ni] : '0;
    e_rdy = !src_on || mode < 2 || coin(50);
    s_rdy = !src_on || mode < 2 || coin(mode == 3 ? 30 : 60);
    #1;
    if (w_vld && w_rdy) wi++;
    if (n_vld && n_rdy) ni++;
    if (e_vld && e_rdy) begin
      chk($sformatf("R3/R4/R8 east[%0d]", ei), e_data, (ei < n_exp) ? exp_e[ei] : 33'h1_FFFF_FFFF);
      ei++;
    end
    if (s_vld && s_rdy) begin
      chk($sformatf("R3/R4/R8 south[%0d]", si), s_data, (si < n_exp) ? exp_s[si] : 33'h1_FFFF_FFFF);
      si++;
    end
    if (perr) errs++;
  endtask

  task automatic run(input int mode);
    wi = 0; ni = 0; ei = 0; si = 0; errs = 0;
    for (int c = 0; c < 3000; c++) begin
      if (wi >= n_pairs && ni >= n_pairs && ei >= n_exp && si >= n_exp) break;
      step(1'b1, mode);
    end
    for (int c = 0; c < 6; c++) step(1'b0, mode);
    chk("R8 east count", 33'(ei), 33'(n_exp));
    chk("R8 south count", 33'(si), 33'(n_exp));
    chk("R6 error pulses", 33'(errs), 33'(n_err_exp));
  endtask

  initial begin
    do_reset();
    #1;
    // R9 / R2 reset state
    chk("R9 east_vld after reset", 33'(e_vld), 33'(0));
    chk("R9 south_vld after reset", 33'(s_vld), 33'(0));
    chk("R9 proto_err after reset", 33'(perr), 33'(0));
    chk("R2 west_rdy after reset", 33'(w_rdy), 33'(1));
    chk("R2 north_rdy after reset", 33'(n_rdy), 33'(1));

    // R7 latency: accepted at edge k, visible after edge k+1
    @(negedge clk);
    e_rdy = 1; s_rdy = 1;
    w_vld = 1; n_vld = 1; w_data = {1'b0, 32'd6}; n_data = {1'b0, 32'd7};
    #1; chk("R7 pair accepted", 33'(w_rdy && n_rdy), 33'(1));
    @(negedge clk); w_vld = 0; n_vld = 0;
    #1; chk("R7 not yet valid", 33'(e_vld || s_vld), 33'(0));
    @(negedge clk); #1;
    chk("R7 east valid", 33'(e_vld), 33'(1));
    chk("R7 south valid", 33'(s_vld), 33'(1));
    chk("R7 east data", e_data, {1'b0, 32'd6});
    chk("R7 south data", s_data, {1'b0, 32'd7});

    // R9: reset zeroes the accumulator (6*7 was added above)
    do_reset();
    @(negedge clk);
    e_rdy = 1; s_rdy = 1;
    w_vld = 1; n_vld = 1; w_data = {1'b1, 32'd9}; n_data = {1'b1, 32'd9};
    @(negedge clk); w_vld = 0; n_vld = 0;
    @(negedge clk); #1;
    chk("R9 accumulator zero after reset", s_data, {1'b1, 32'd0});
    chk("R4 east zero in result mode", e_data, {1'b1, 32'd0});

    // R5 / R2: east stalled, south free
    do_reset();
    wi = 0; si = 0; ei = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      e_rdy = 0; s_rdy = 1;
      w_vld = 1; n_vld = 1;
      w_data = {1'b0, 32'(100 + wi)}; n_data = {1'b0, 32'(200 + wi)};
      #1;
      if (w_vld && w_rdy) wi++;
      if (s_vld && s_rdy) si++;
    end
    chk("R5 west accepted while east stalled", 33'(wi), 33'(1 + 2));
    chk("R5 south moved once while east stalled", 33'(si), 33'(1));
    chk("R2 west_rdy low when queue full", 33'(w_rdy), 33'(0));
    chk("R8 east held", e_data, {1'b0, 32'd100});
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      w_vld = 0; n_vld = 0; e_rdy = 1; s_rdy = 1;
      #1;
      if (e_vld) begin
        chk("R5 east order", e_data, {1'b0, 32'(100 + ei)});
        ei++;
      end
      if (s_vld) si++;
    end
    chk("R5 east total", 33'(ei), 33'(3));
    chk("R5 south total", 33'(si), 33'(3));

    // sweeps: scenarios x stall patterns (R1, R3, R4, R5, R6, R8)
    for (int s = 0; s < 6; s++) begin
      for (int m = 0; m < 4; m++) begin
        do_reset();
        build(s);
        run(m);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule